// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block models a synchronous static RAM whose address, control and write data are all captured on the rising clock edge. Each word holds four 9-bit lanes (eight data bits and one parity bit per lane). An access begins when either of two start strobes is sampled low while all three selects are active. One strobe serves a processor and the other serves a cache controller. The start address is loaded into an internal two-bit beat counter. Later beats of up to four per burst are produced internally whenever the advance input is low. A static mode pin chooses whether beats step in wrapping-increment order or in XOR (interleaved) order.

Read data passes through one output register, so a word appears, flagged by `rvalid`, one edge after the edge that captured its address. A write can cover every lane at once through the global write input, or selected lanes through the lane-write enable combined with per-lane selects. A start cycle raised by the processor strobe is always a read. The output enable and the sleep input gate the outputs combinationally. Sleep also blocks new accesses and writes, and it ends any burst in progress.

Top module: `pbs_sram`

## Requirements
- R1: While `rst_n` is low and after its release, before any access, `rvalid` is 0 and `rdata` is all zeros.
- R2: When either start strobe (`strb_cpu_n` or `strb_ctl_n`) is low at an edge, and `ce_n`=0, `cs_hi`=1 and `cs_lo_n`=0, the address is loaded. For a read, the word at that address appears on `rdata` with `rvalid`=1 after the following edge.
- R3: In an active burst without a strobe, `adv_n`=0 moves to the next beat, and `adv_n`=1 keeps the current address, so the same word is read again.
- R4: With `seq_linear`=1, the low two address bits of beat k are (start + k) mod 4 and the upper bits stay fixed. After the fourth beat, the next advance returns to the start address.
- R5: With `seq_linear`=0, the low two address bits of beat k are start XOR k.
- R6: `wr_all_n`=0 in a write-capable cycle writes all four lanes. Lane b takes `wdata[9b+8:9b]`.
- R7: With `wr_all_n`=1 and `byte_wr_n`=0, only lanes whose `byte_sel_n[b]` is 0 are written. If no lane is selected, the cycle is a read.
- R8: A start cycle raised by `strb_cpu_n` is a read, whatever the write inputs are.
- R9: A start strobe with any select inactive ends the access. No valid data results from that cycle or from later cycles until the next selected start.
- R10: `oe_n`=1 forces `rvalid` to 0 and `rdata` to zero in the same cycle, without disturbing the pipeline.
- R11: `sleep`=1 forces outputs invalid in the same cycle, ignores strobes and writes, and ends any active burst.
- R12: A write cycle produces no valid read data. A later read of the written address returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Start address, loaded on a start strobe |
| ce_n | input | 1 | Select, active low |
| cs_hi | input | 1 | Select, active high |
| cs_lo_n | input | 1 | Select, active low |
| strb_cpu_n | input | 1 | Processor start strobe, active low (read only) |
| strb_ctl_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Beat advance, active low |
| seq_linear | input | 1 | 1: wrapping increment order, 0: XOR order |
| wr_all_n | input | 1 | Global write, active low |
| byte_wr_n | input | 1 | Lane-write enable, active low |
| byte_sel_n | input | NB | Per-lane write select, active low |
| wdata | input | NB*LW | Write data, lane b at bits 9b+8:9b |
| oe_n | input | 1 | Output enable, active low, combinational |
| sleep | input | 1 | Low-power idle, active high |
| rdata | output | NB*LW | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The assertions assume that `seq_linear` stays constant from a start cycle to the end of that burst. They also assume that inputs carry no unknowns once reset is released. The linear-step and hold properties rely on that mode being steady. The stimulus therefore changes the mode only together with a start strobe, and drives every input at the falling edge. Every word the bench reads has been written earlier with a known value, so the array's unwritten contents never reach a comparison.

// File: rtl/pbs_pkg.sv
// Package: shared constants and the beat-order function of the burst SRAM.
// Assumes a burst of exactly four beats, indexed by a two-bit counter.
package pbs_pkg;

    localparam int BEAT_W = 2;

    // Low address bits of beat 'beat' for a burst that started at 'start'.
    function automatic logic [BEAT_W-1:0] beat_low(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              linear
    );
        return linear ? (start + beat) : (start ^ beat);
    endfunction

endpackage

// File: rtl/pbs_burst_ctr.sv
// Burst address generator: holds the base address and beat index and
// produces the address for the current cycle combinationally.
// Assumes AW >= 3 and that 'load' and 'step' are never both high.
module pbs_burst_ctr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          linear,
    input  logic [AW-1:0] load_addr,
    output logic [AW-1:0] cur_addr
);
    localparam int BW = pbs_pkg::BEAT_W;

    logic [AW-1:0] base_q, base_n;
    logic [BW-1:0] beat_q, beat_n;

    // Next base and beat: load restarts the burst, step advances it.
    always_comb begin
        base_n = load ? load_addr : base_q;
        if (load)
            beat_n = '0;
        else if (step)
            beat_n = beat_q + BW'(1);
        else
            beat_n = beat_q;
    end

    assign cur_addr = {base_n[AW-1:BW], pbs_pkg::beat_low(base_n[BW-1:0], beat_n, linear)};

    // Keep base and beat for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else begin
            base_q <= base_n;
            beat_q <= beat_n;
        end
    end
endmodule

// File: rtl/pbs_wr_decode.sv
// Write-lane decoder: turns the global and per-lane write inputs into a
// lane mask. Assumes 'en' already excludes cycles that may not write.
module pbs_wr_decode #(
    parameter int NB = 4
) (
    input  logic          en,
    input  logic          wr_all_n,
    input  logic          byte_wr_n,
    input  logic [NB-1:0] byte_sel_n,
    output logic [NB-1:0] mask
);
    for (genvar b = 0; b < NB; b++) begin : g_lane
        // Global write covers the lane; otherwise it needs enable and its select.
        assign mask[b] = en & (~wr_all_n | (~byte_wr_n & ~byte_sel_n[b]));
    end
endmodule

// File: rtl/pbs_array.sv
// Storage array: one memory per lane with a masked write port and a
// registered read port. Assumes the write address and the read address
// may be equal. A read at the same edge returns the value before the write.
module pbs_array #(
    parameter int AW = 8,
    parameter int NB = 4,
    parameter int LW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NB-1:0]    wr_mask,
    input  logic [AW-1:0]    wr_addr,
    input  logic [NB*LW-1:0] wdata,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [NB*LW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];
        logic [LW-1:0] q;

        // Commit this lane's write data when its mask bit is set.
        always_ff @(posedge clk) begin
            if (wr_mask[b])
                mem[wr_addr] <= wdata[b*LW +: LW];
        end

        // Register this lane's read word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (rd_en)
                q <= mem[rd_addr];
        end

        assign rd_data[b*LW +: LW] = q;
    end
endmodule

// File: rtl/pbs_sram.sv
// Top level of the pipelined burst SRAM: start decode, burst control,
// write gating, and the one-stage read pipeline with output gating.
// Assumes seq_linear is steady for the length of a burst.
module pbs_sram #(
    parameter int AW = 8,
    parameter int NB = 4,
    parameter int LW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             ce_n,
    input  logic             cs_hi,
    input  logic             cs_lo_n,
    input  logic             strb_cpu_n,
    input  logic             strb_ctl_n,
    input  logic             adv_n,
    input  logic             seq_linear,
    input  logic             wr_all_n,
    input  logic             byte_wr_n,
    input  logic [NB-1:0]    byte_sel_n,
    input  logic [NB*LW-1:0] wdata,
    input  logic             oe_n,
    input  logic             sleep,
    output logic [NB*LW-1:0] rdata,
    output logic             rvalid
);
    localparam int DW = NB * LW;

    logic          sel, start, cpu_start, go, step, live, rd_now, out_en;
    logic          active_q, rd_q, rvalid_q;
    logic [AW-1:0] cur_addr, addr_q;
    logic [NB-1:0] wr_mask;
    logic [DW-1:0] rd_data;

    // Decode selects and start conditions for this cycle.
    always_comb begin
        sel       = ~ce_n & cs_hi & ~cs_lo_n;
        start     = ~sleep & (~strb_cpu_n | ~strb_ctl_n);
        cpu_start = start & ~strb_cpu_n;
        go        = start & sel;
        step      = ~sleep & ~start & active_q & ~adv_n;
        live      = go | (~sleep & ~start & active_q);
    end

    pbs_burst_ctr #(.AW(AW)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (go),
        .step      (step),
        .linear    (seq_linear),
        .load_addr (addr),
        .cur_addr  (cur_addr)
    );

    pbs_wr_decode #(.NB(NB)) u_wdec (
        .en         (live & ~cpu_start),
        .wr_all_n   (wr_all_n),
        .byte_wr_n  (byte_wr_n),
        .byte_sel_n (byte_sel_n),
        .mask       (wr_mask)
    );

    assign rd_now = live & ~(|wr_mask);

    // Track burst activity, the pending read, and the captured address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            rd_q     <= 1'b0;
            rvalid_q <= 1'b0;
            addr_q   <= '0;
        end else begin
            if (sleep)
                active_q <= 1'b0;
            else if (start)
                active_q <= sel;
            rd_q     <= rd_now;
            rvalid_q <= rd_q & ~sleep;
            addr_q   <= cur_addr;
        end
    end

    pbs_array #(.AW(AW), .NB(NB), .LW(LW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (wr_mask),
        .wr_addr (cur_addr),
        .wdata   (wdata),
        .rd_en   (rd_q),
        .rd_addr (addr_q),
        .rd_data (rd_data)
    );

    // Gate the outputs with output enable and sleep.
    assign out_en = rvalid_q & ~oe_n & ~sleep;
    assign rvalid = out_en;
    assign rdata  = out_en ? rd_data : '0;
endmodule

// File: rtl/pbs_sram_chk.sv
// Checker for pbs_sram: temporal properties over ports and internal
// control state. Assumes seq_linear is steady within a burst.
module pbs_sram_chk #(
    parameter int AW = 8,
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          cs_hi,
    input logic          cs_lo_n,
    input logic          strb_cpu_n,
    input logic          strb_ctl_n,
    input logic          adv_n,
    input logic          seq_linear,
    input logic          oe_n,
    input logic          sleep,
    input logic [DW-1:0] rdata,
    input logic          rvalid,
    input logic          active_q,
    input logic          rd_q,
    input logic [AW-1:0] addr_q,
    input logic [3:0]    wr_mask
);
    logic sel_c, nostrb;
    assign sel_c  = ~ce_n & cs_hi & ~cs_lo_n;
    assign nostrb = strb_cpu_n & strb_ctl_n;

    p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!rvalid && rdata == '0));

    p_sleep_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !active_q);

    p_hold_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !sleep && nostrb && adv_n) |=> (addr_q == $past(addr_q)));

    p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !sleep && nostrb && !adv_n && seq_linear) |=>
        (addr_q[1:0] == $past(addr_q[1:0]) + 2'd1 && addr_q[AW-1:2] == $past(addr_q[AW-1:2])));

    p_cpu_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_cpu_n && !sleep && sel_c) |=> rd_q);

    p_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !nostrb && !sel_c) |=> ##1 !rvalid);

    p_write_no_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_mask) |=> !rd_q);
endmodule

bind pbs_sram pbs_sram_chk #(.AW(AW), .DW(NB*LW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .cs_hi      (cs_hi),
    .cs_lo_n    (cs_lo_n),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .adv_n      (adv_n),
    .seq_linear (seq_linear),
    .oe_n       (oe_n),
    .sleep      (sleep),
    .rdata      (rdata),
    .rvalid     (rvalid),
    .active_q   (active_q),
    .rd_q       (rd_q),
    .addr_q     (addr_q),
    .wr_mask    (wr_mask)
);

// File: tb/pbs_sram_tb.sv
// Scoreboard bench: each driven cycle pushes its expected result; a monitor
// pops and compares one item per cycle, applying the output gating itself.
module pbs_sram_tb;
    localparam int AW = 8;
    localparam int NB = 4;
    localparam int LW = 9;
    localparam int DW = NB * LW;

    typedef struct {
        int            due;
        logic          vld;
        logic [DW-1:0] dat;
        string         req;
    } exp_t;

    logic          clk = 0, rst_n = 0;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 0, cs_hi = 1, cs_lo_n = 0;
    logic          strb_cpu_n = 1, strb_ctl_n = 1, adv_n = 1, seq_linear = 1;
    logic          wr_all_n = 1, byte_wr_n = 1;
    logic [NB-1:0] byte_sel_n = '1;
    logic [DW-1:0] wdata = '0;
    logic          oe_n = 0, sleep = 0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    logic nx_ce_n = 0, nx_cs_hi = 1, nx_cs_lo_n = 0, nx_oe_n = 0, nx_sleep = 0, nx_lin = 1;

    int    checks = 0, errors = 0, cyc = 0;
    bit    done = 0;
    string cur_req = "R1";
    exp_t  sq[$];

    logic [DW-1:0] ref_mem [1 << AW];
    logic          m_act = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;

    always #2.5 clk = ~clk;

    pbs_sram u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .cs_hi(cs_hi),
        .cs_lo_n(cs_lo_n), .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
        .adv_n(adv_n), .seq_linear(seq_linear), .wr_all_n(wr_all_n),
        .byte_wr_n(byte_wr_n), .byte_sel_n(byte_sel_n), .wdata(wdata),
        .oe_n(oe_n), .sleep(sleep), .rdata(rdata), .rvalid(rvalid)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] pat(input logic [7:0] a, input logic [7:0] k);
        return {4'hA, a, ~a, a + k, a ^ 8'h3C};
    endfunction

    // Bench reference of one cycle, built from the requirements, then the edge.
    task automatic tick();
        logic sel_b, start_b, cpu_b, live_b;
        logic [NB-1:0] m;
        logic [AW-1:0] cur;
        exp_t it;
        sel_b   = !ce_n && cs_hi && !cs_lo_n;
        start_b = !sleep && (!strb_cpu_n || !strb_ctl_n);
        cpu_b   = start_b && !strb_cpu_n;
        live_b  = 0;
        if (sleep) m_act = 0;
        else if (start_b) begin
            m_act = sel_b;
            if (sel_b) begin m_base = addr; m_beat = 0; live_b = 1; end
        end else if (m_act) begin
            live_b = 1;
            if (!adv_n) m_beat = m_beat + 2'd1;
        end
        cur = {m_base[AW-1:2], seq_linear ? m_base[1:0] + m_beat : m_base[1:0] ^ m_beat};
        m = '0;
        if (live_b && !cpu_b) m = !wr_all_n ? '1 : (!byte_wr_n ? ~byte_sel_n : '0);
        it.vld = live_b && (m == '0);
        it.dat = it.vld ? ref_mem[cur] : '0;
        it.req = cur_req;
        for (int b = 0; b < NB; b++)
            if (m[b]) ref_mem[cur][b*LW +: LW] = wdata[b*LW +: LW];
        @(posedge clk);
        #1;
        it.due = cyc + 1;
        sq.push_back(it);
    endtask

    task automatic drive(input logic cpu_n, input logic ctl_n, input logic av_n,
                         input logic [AW-1:0] a, input logic wa_n, input logic bw_n,
                         input logic [NB-1:0] bs_n, input logic [DW-1:0] wd);
        @(negedge clk);
        strb_cpu_n = cpu_n; strb_ctl_n = ctl_n; adv_n = av_n; addr = a;
        wr_all_n = wa_n; byte_wr_n = bw_n; byte_sel_n = bs_n; wdata = wd;
        ce_n = nx_ce_n; cs_hi = nx_cs_hi; cs_lo_n = nx_cs_lo_n;
        oe_n = nx_oe_n; sleep = nx_sleep; seq_linear = nx_lin;
        tick();
    endtask

    task automatic rd_ctl(input logic [AW-1:0] a); drive(1, 0, 1, a, 1, 1, '1, '0); endtask
    task automatic rd_cpu(input logic [AW-1:0] a); drive(0, 1, 1, a, 1, 1, '1, '0); endtask
    task automatic step_rd();                      drive(1, 1, 0, '0, 1, 1, '1, '0); endtask
    task automatic hold();                         drive(1, 1, 1, '0, 1, 1, '1, '0); endtask
    task automatic wr_ctl(input logic [AW-1:0] a, input logic [DW-1:0] d); drive(1, 0, 1, a, 0, 1, '1, d); endtask
    task automatic wr_step(input logic [DW-1:0] d); drive(1, 1, 0, '0, 0, 1, '1, d); endtask

    // Monitor: compare one expected item per cycle, gated by oe_n and sleep.
    always @(posedge clk) begin
        #1;
        if (sq.size() > 0 && sq[0].due == cyc) begin
            exp_t it;
            logic ev;
            logic [DW-1:0] ed;
            it = sq.pop_front();
            ev = it.vld && !oe_n && !sleep;
            ed = ev ? it.dat : '0;
            checks++;
            if (rvalid !== ev || rdata !== ed) begin
                errors++;
                $display("FAIL %s: actual rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                         it.req, rvalid, rdata, ev, ed);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual run still busy expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (rvalid !== 1'b0 || rdata !== '0) begin
            errors++;
            $display("FAIL R1: actual rvalid=%0b rdata=%h expected 0/0", rvalid, rdata);
        end
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        checks++;
        if (rvalid !== 1'b0 || rdata !== '0) begin
            errors++;
            $display("FAIL R1: actual rvalid=%0b rdata=%h expected 0/0 after release", rvalid, rdata);
        end

        // R6, R4, R12: global-write linear burst at 0x10..0x13
        cur_req = "R6"; nx_lin = 1;
        wr_ctl(8'h10, pat(8'h10, 1));
        for (int i = 1; i < 4; i++) wr_step(pat(8'h10 + 8'(i), 1));
        // R5, R12: interleaved write burst from 0x21 -> 21,20,23,22
        cur_req = "R5"; nx_lin = 0;
        wr_ctl(8'h21, pat(8'h21, 2));
        for (int i = 1; i < 4; i++) wr_step(pat(8'h60 + 8'(i), 2));
        // R2, R4: linear read from 0x12 -> 12,13,10,11 then wrap to 12
        cur_req = "R4"; nx_lin = 1;
        rd_ctl(8'h12);
        for (int i = 0; i < 4; i++) step_rd();
        // R3: hold repeats the same word
        cur_req = "R3";
        hold(); hold();
        // R5, R2: interleaved read from 0x23 on the processor strobe -> 23,22,21,20
        cur_req = "R5"; nx_lin = 0;
        rd_cpu(8'h23);
        for (int i = 0; i < 3; i++) step_rd();
        // R7: lane writes to 0x10 (lanes 0,2), 0x11 (lane 3), then 0x12 with no lane (read)
        cur_req = "R7"; nx_lin = 1;
        drive(1, 0, 1, 8'h10, 1, 0, 4'b1010, 36'h5_5555_5555);
        drive(1, 1, 0, '0,    1, 0, 4'b0111, 36'hF_0F0F_0F0F);
        drive(1, 1, 0, '0,    1, 0, 4'b1111, 36'h0_1234_5678);
        rd_ctl(8'h10); step_rd(); step_rd();
        // R8: processor start with write inputs is a read; memory unchanged
        cur_req = "R8";
        drive(0, 1, 1, 8'h20, 0, 0, 4'b0000, 36'hB_BBBB_BBBB);
        hold();
        rd_ctl(8'h20);
        // R12: read after write of the same address
        cur_req = "R12";
        wr_ctl(8'h40, pat(8'h40, 7));
        rd_ctl(8'h40);
        hold();
        // R9: each select inactive in turn
        cur_req = "R9";
        rd_ctl(8'h11);
        nx_ce_n = 1; rd_ctl(8'h11); nx_ce_n = 0; hold(); hold();
        rd_ctl(8'h11);
        nx_cs_hi = 0; rd_cpu(8'h11); nx_cs_hi = 1; hold(); step_rd();
        rd_ctl(8'h11);
        nx_cs_lo_n = 1; rd_ctl(8'h11); nx_cs_lo_n = 0; hold(); hold();
        // R10: output enable high for one cycle mid burst
        cur_req = "R10";
        rd_ctl(8'h10); step_rd();
        nx_oe_n = 1; step_rd(); nx_oe_n = 0;
        step_rd(); hold();
        // R11: sleep ends the burst and blocks a strobed write
        cur_req = "R11";
        rd_ctl(8'h12); step_rd();
        nx_sleep = 1; wr_ctl(8'h40, 36'h0_DEAD_BEEF); nx_sleep = 0;
        step_rd(); hold();
        rd_ctl(8'h40); hold();
        // drain
        cur_req = "R9";
        nx_ce_n = 1; rd_ctl(8'h00); nx_ce_n = 0;
        hold(); hold();
        @(posedge clk); #2;
        checks++;
        if (sq.size() > 1) begin
            errors++;
            $display("FAIL R2: actual %0d pending results expected at most 1", sq.size());
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule